// File: doc/BRIEF.md
# Write-Status Polling Bit Generator

This block sits on the device side of a flash array and produces the value that a host reads on data bit 7 while an internal program or erase algorithm runs. A host polls bit 7 at the target address. While the operation is pending the bit carries a "not yet" value: the inverted data bit for a program, zero for an erase. When the operation is over, the bit carries the final value: the true data bit for a program, one for an erase. An erase held in suspend also reads as one. A program may be started while an erase is suspended. Once that program finishes, the block goes back to reporting the suspended erase.

When the target of a program, or every sector picked for an erase, is protected, nothing is written. The block still shows a busy status for a fixed window and then goes back to plain array reads. A single down-counter times both windows. Its lengths, in clock cycles, are parameters. Outside an operation or a window the status flag is low and bit 7 follows the array data.

The command decoder signals the rising edge of the final write strobe of a command sequence with a one-cycle `op_start` pulse. Status becomes active on the clock after that pulse.

Top module: `poll_status_top`

## Requirements
- R1: While `rst` is high and on the cycle after it, `status_mode` is 0 and `dq7_out` equals `array_bit7`.
- R2: On the cycle that carries an accepted `op_start` pulse, `status_mode` is still 0 and `dq7_out` equals `array_bit7`. From the next cycle `status_mode` is 1.
- R3: During an unprotected program (`op_is_erase`=0), while `engine_busy` is 1, `dq7_out` is the inverse of the `prog_bit7` captured with `op_start`.
- R4: On the first cycle of a program with `engine_busy` at 0, `dq7_out` equals the captured data bit and `status_mode` is still 1. On the next cycle `status_mode` is 0.
- R5: During an unprotected erase (`op_is_erase`=1), `dq7_out` is 0 while `engine_busy` is 1 and `erase_susp` is 0. On the cycle where both are 0, `dq7_out` is 1 and `status_mode` is still 1. On the next cycle status ends.
- R6: While an erase is running and `erase_susp` is 1, `status_mode` stays 1 and `dq7_out` is 1.
- R7: A program started during a suspended erase shows the R3/R4 complement-then-true values, or the R8 window if it is protected. It then returns to the suspended erase, with `status_mode`=1 and `dq7_out`=1.
- R8: A program with `target_prot`=1 at `op_start` holds `status_mode`=1 and `dq7_out`=inverse data for exactly `PROG_WIN_CYC` cycles. During that window `engine_busy`, `erase_susp` and `target_prot` are ignored. After the window, array reads resume.
- R9: An erase with `target_prot`=1 at `op_start` holds `status_mode`=1 and `dq7_out`=0 for exactly `ERASE_WIN_CYC` cycles, then array reads resume.
- R10: An `op_start` pulse during an active operation or window is ignored. The one exception is a program during a suspended erase.
- R11: With no operation or window active, `status_mode` is 0 and `dq7_out` follows `array_bit7` in the same cycle.
- R12: A synchronous reset during an operation or window ends it on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | One-cycle pulse at the final write strobe of a command |
| op_is_erase | input | 1 | Operation kind at `op_start`: 1 erase, 0 program |
| prog_bit7 | input | 1 | Data bit 7 being programmed, captured at `op_start` |
| engine_busy | input | 1 | Algorithm engine is running |
| erase_susp | input | 1 | Erase suspend is in effect |
| target_prot | input | 1 | Program target, or all erase targets, protected |
| array_bit7 | input | 1 | Bit 7 read from the cell array |
| dq7_out | output | 1 | Value presented on data bit 7 |
| status_mode | output | 1 | Bit 7 carries polling status instead of array data |

## Verification
The bench measures the protected windows cycle by cycle against their parameters. A counter that is one cycle off would make the status either end one read early or hang one read late. The bench also nests a program, both unprotected and protected, inside a suspended erase. A design that forgot the parked erase would drop to array reads instead of showing 1. Extra `op_start` pulses arrive mid-operation carrying inverted data and the other kind; a design that re-captured them would flip bit 7. A reset issued in the middle of a run checks that no stale window or context survives it.

// File: rtl/poll_pkg.sv
package poll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_WIN  = 2'd2
    } poll_state_e;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        logic     bit7;
    } op_ctx_t;

    // Status value for bit 7: pending shows the "not done" value,
    // otherwise the final value of the operation.
    function automatic logic poll_value(op_ctx_t c, logic pending);
        if (c.kind == OP_PROG)
            return pending ? ~c.bit7 : c.bit7;
        else
            return ~pending;
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/poll_win_timer.sv
module poll_win_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          active,
    output logic          expire
);
    logic [CW-1:0] cnt_q;

    assign expire = active && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt_q  <= '0;
        end else if (load) begin
            active <= 1'b1;
            cnt_q  <= load_val;
        end else if (active) begin
            if (cnt_q == '0)
                active <= 1'b0;
            else
                cnt_q <= cnt_q - CW'(1);
        end
    end

    // R8 / R9: a loaded window is armed on the next cycle
    a_r8_load_arms: assert property (@(posedge clk) disable iff (rst)
        load |=> active);

    // R8 / R9: every window cycle removes exactly one count
    a_r9_count_steps: assert property (@(posedge clk) disable iff (rst)
        (active && (cnt_q != '0) && !load) |=> (active && (cnt_q == $past(cnt_q) - CW'(1))));

endmodule

// File: rtl/poll_fsm.sv
module poll_fsm
    import poll_pkg::*;
#(
    parameter int unsigned PROG_WIN_CYC  = 100_000,
    parameter int unsigned ERASE_WIN_CYC = 5_000_000,
    parameter int unsigned CW            = 23
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    op_start,
    input  logic    op_is_erase,
    input  logic    prog_bit7,
    input  logic    engine_busy,
    input  logic    erase_susp,
    input  logic    target_prot,
    output logic    status_mode,
    output logic    pending,
    output op_ctx_t ctx
);
    localparam logic [CW-1:0] PROG_RELOAD  = CW'(PROG_WIN_CYC - 1);
    localparam logic [CW-1:0] ERASE_RELOAD = CW'(ERASE_WIN_CYC - 1);

    poll_state_e state_q;
    op_ctx_t     ctx_q;
    logic        parked_q;
    logic        accept, run_done, win_load, win_active, win_expire, leave;
    logic        susp_erase_now;
    logic [CW-1:0] win_reload;

    assign susp_erase_now = (state_q == ST_RUN) && (ctx_q.kind == OP_ERASE)
                            && erase_susp && !parked_q;

    assign accept = op_start && ((state_q == ST_IDLE) ||
                                 (susp_erase_now && !op_is_erase));

    always_comb begin
        run_done = 1'b0;
        if (state_q == ST_RUN) begin
            if (ctx_q.kind == OP_PROG)
                run_done = !engine_busy;
            else
                run_done = !engine_busy && !erase_susp;
        end
    end

    always_comb begin
        pending = 1'b0;
        case (state_q)
            ST_RUN:  pending = (ctx_q.kind == OP_PROG) ? engine_busy
                                                       : (engine_busy && !erase_susp);
            ST_WIN:  pending = 1'b1;
            default: pending = 1'b0;
        endcase
    end

    assign leave      = run_done || (state_q == ST_WIN && win_expire);
    assign win_load   = accept && target_prot;
    assign win_reload = op_is_erase ? ERASE_RELOAD : PROG_RELOAD;

    poll_win_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (win_load),
        .load_val (win_reload),
        .active   (win_active),
        .expire   (win_expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            ctx_q    <= '{kind: OP_PROG, bit7: 1'b0};
            parked_q <= 1'b0;
        end else if (accept) begin
            state_q  <= target_prot ? ST_WIN : ST_RUN;
            ctx_q    <= '{kind: op_kind_e'(op_is_erase), bit7: prog_bit7};
            parked_q <= (state_q == ST_RUN);
        end else if (leave) begin
            if (parked_q) begin
                state_q    <= ST_RUN;
                ctx_q.kind <= OP_ERASE;
                parked_q   <= 1'b0;
            end else begin
                state_q <= ST_IDLE;
            end
        end
    end

    assign status_mode = (state_q != ST_IDLE);
    assign ctx         = ctx_q;

    // R1 / R12: reset always lands in the idle state
    a_r12_reset_idles: assert property (@(posedge clk)
        rst |=> (state_q == ST_IDLE));

    // R2: accepted start raises status on the following cycle
    a_r2_start_raises: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && op_start) |=> status_mode);

    // R11: idle without a start stays idle
    a_r11_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !op_start) |=> (state_q == ST_IDLE));

    // R10: a start during a window leaves the captured context alone
    a_r10_win_ignores: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WIN && !win_expire && op_start) |=> $stable(ctx_q));

    // R8 / R9: the window state and the timer agree
    a_r8_win_timed: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WIN) |-> win_active);

endmodule

// File: rtl/poll_drive.sv
module poll_drive
    import poll_pkg::*;
(
    input  logic    status_mode,
    input  logic    pending,
    input  op_ctx_t ctx,
    input  logic    array_bit7,
    output logic    dq7_out
);
    assign dq7_out = status_mode ? poll_value(ctx, pending) : array_bit7;
endmodule

// File: rtl/poll_status_top.sv
module poll_status_top
    import poll_pkg::*;
#(
    parameter int unsigned PROG_WIN_CYC  = 100_000,
    parameter int unsigned ERASE_WIN_CYC = 5_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic op_start,
    input  logic op_is_erase,
    input  logic prog_bit7,
    input  logic engine_busy,
    input  logic erase_susp,
    input  logic target_prot,
    input  logic array_bit7,
    output logic dq7_out,
    output logic status_mode
);
    localparam int unsigned WIN_MAX = max_u(PROG_WIN_CYC, ERASE_WIN_CYC);
    localparam int unsigned CW      = (WIN_MAX < 2) ? 1 : $clog2(WIN_MAX);

    logic    pending;
    op_ctx_t ctx;

    poll_fsm #(
        .PROG_WIN_CYC  (PROG_WIN_CYC),
        .ERASE_WIN_CYC (ERASE_WIN_CYC),
        .CW            (CW)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .op_start    (op_start),
        .op_is_erase (op_is_erase),
        .prog_bit7   (prog_bit7),
        .engine_busy (engine_busy),
        .erase_susp  (erase_susp),
        .target_prot (target_prot),
        .status_mode (status_mode),
        .pending     (pending),
        .ctx         (ctx)
    );

    poll_drive u_drive (
        .status_mode (status_mode),
        .pending     (pending),
        .ctx         (ctx),
        .array_bit7  (array_bit7),
        .dq7_out     (dq7_out)
    );

    // R1: status is off on the cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> !status_mode);

endmodule

// File: tb/test_poll_status_top.sv
module test_poll_status_top;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 7;
    localparam int EW = 13;

    logic clk = 1'b0;
    logic rst, op_start, op_is_erase, prog_bit7, engine_busy, erase_susp, target_prot, array_bit7;
    logic dq7_out, status_mode;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    poll_status_top #(.PROG_WIN_CYC(PW), .ERASE_WIN_CYC(EW)) i_poll_status_top (
        .clk(clk), .rst(rst), .op_start(op_start), .op_is_erase(op_is_erase),
        .prog_bit7(prog_bit7), .engine_busy(engine_busy), .erase_susp(erase_susp),
        .target_prot(target_prot), .array_bit7(array_bit7),
        .dq7_out(dq7_out), .status_mode(status_mode)
    );

    function automatic logic exp_prog(logic d, logic busy);
        return busy ? ~d : d;
    endfunction

    function automatic logic exp_erase(logic busy, logic susp);
        return !(busy && !susp);
    endfunction

    task automatic chk(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic expect2(string req, logic sm, logic d7);
        chk({req, " status_mode"}, status_mode, sm);
        chk({req, " dq7_out"}, dq7_out, d7);
    endtask

    task automatic cyc();
        @(negedge clk);
        op_start = 1'b0;
        array_bit7 = 1'($urandom);
    endtask

    task automatic run_prog(logic d, int n);
        cyc(); op_start = 1; op_is_erase = 0; prog_bit7 = d; engine_busy = 1; target_prot = 0;
        #1 expect2("R2 prog start", 0, array_bit7);
        for (int i = 0; i < n; i++) begin
            cyc();
            target_prot = 1'($urandom);
            if (i == 1) begin op_start = 1; op_is_erase = 1; prog_bit7 = ~d; end
            else begin op_is_erase = 0; prog_bit7 = d; end
            #1 expect2((i == 2) ? "R10 start ignored" : "R3 prog busy", 1, exp_prog(d, 1));
        end
        cyc(); engine_busy = 0; target_prot = 0;
        #1 expect2("R4 prog done", 1, exp_prog(d, 0));
        cyc();
        #1 expect2("R11 idle after prog", 0, array_bit7);
    endtask

    task automatic run_erase(int n, bit do_susp, bit do_prog, logic d);
        cyc(); op_start = 1; op_is_erase = 1; engine_busy = 1; erase_susp = 0; target_prot = 0;
        #1 expect2("R2 erase start", 0, array_bit7);
        for (int i = 0; i < n; i++) begin
            cyc();
            #1 expect2("R5 erase busy", 1, exp_erase(1, 0));
        end
        if (do_susp) begin
            for (int i = 0; i < 3; i++) begin
                cyc(); engine_busy = 0; erase_susp = 1;
                if (i == 1) begin op_start = 1; op_is_erase = 1; end
                #1 expect2((i == 2) ? "R10 erase restart ignored" : "R6 suspended", 1, 1);
            end
            if (do_prog) begin
                cyc(); op_start = 1; op_is_erase = 0; prog_bit7 = d; engine_busy = 1;
                #1 expect2("R6 suspended at prog start", 1, 1);
                for (int i = 0; i < 3; i++) begin
                    cyc();
                    #1 expect2("R7 prog in suspend busy", 1, exp_prog(d, 1));
                end
                cyc(); engine_busy = 0;
                #1 expect2("R7 prog in suspend done", 1, exp_prog(d, 0));
                cyc();
                #1 expect2("R7 back to suspended erase", 1, 1);
            end
            for (int i = 0; i < 2; i++) begin
                cyc(); erase_susp = 0; engine_busy = 1;
                #1 expect2("R5 erase resumed", 1, 0);
            end
        end
        cyc(); engine_busy = 0; erase_susp = 0;
        #1 expect2("R5 erase done", 1, 1);
        cyc();
        #1 expect2("R11 idle after erase", 0, array_bit7);
    endtask

    task automatic run_win(logic is_erase, logic d);
        int len;
        len = is_erase ? EW : PW;
        cyc(); op_start = 1; op_is_erase = is_erase; prog_bit7 = d; target_prot = 1; engine_busy = 0;
        #1 expect2("R2 window start", 0, array_bit7);
        for (int i = 0; i < len; i++) begin
            cyc();
            engine_busy = 1'($urandom); erase_susp = 1'($urandom); target_prot = 1'($urandom);
            prog_bit7 = 1'($urandom);
            if (i == 2) begin op_start = 1; op_is_erase = ~is_erase; end
            #1 expect2(is_erase ? "R9 erase window" : "R8 prog window", 1, is_erase ? 1'b0 : ~d);
        end
        cyc(); engine_busy = 0; erase_susp = 0; target_prot = 0;
        #1 expect2(is_erase ? "R9 window over" : "R8 window over", 0, array_bit7);
    endtask

    task automatic run_parked_win(logic d);
        cyc(); op_start = 1; op_is_erase = 1; engine_busy = 1; erase_susp = 0; target_prot = 0;
        #1 expect2("R2 erase start", 0, array_bit7);
        cyc(); engine_busy = 0; erase_susp = 1;
        #1 expect2("R6 suspended", 1, 1);
        cyc(); op_start = 1; op_is_erase = 0; prog_bit7 = d; target_prot = 1;
        #1 expect2("R6 suspended at prog start", 1, 1);
        for (int i = 0; i < PW; i++) begin
            cyc(); target_prot = 0; engine_busy = 1'($urandom);
            #1 expect2("R7 protected prog in suspend", 1, ~d);
        end
        cyc(); engine_busy = 0;
        #1 expect2("R7 back to suspended erase", 1, 1);
        cyc(); erase_susp = 0;
        #1 expect2("R5 erase done", 1, 1);
        cyc();
        #1 expect2("R11 idle", 0, array_bit7);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1; op_start = 0; op_is_erase = 0; prog_bit7 = 0; engine_busy = 0;
        erase_susp = 0; target_prot = 0; array_bit7 = 0;
        for (int i = 0; i < 3; i++) begin
            cyc(); engine_busy = 1'($urandom);
            #1 expect2("R1 in reset", 0, array_bit7);
        end
        cyc(); rst = 0; engine_busy = 0;
        #1 expect2("R1 after reset", 0, array_bit7);
        for (int i = 0; i < 4; i++) begin
            cyc();
            #1 expect2("R11 idle passthrough", 0, array_bit7);
        end

        run_prog(1'b0, 3);
        run_prog(1'b1, 3);
        for (int i = 0; i < 12; i++) run_prog(1'($urandom), 2 + int'($urandom_range(0, 5)));

        run_erase(3, 0, 0, 0);
        run_erase(2, 1, 0, 0);
        run_erase(2, 1, 1, 1'b0);
        run_erase(2, 1, 1, 1'b1);
        for (int i = 0; i < 8; i++)
            run_erase(1 + int'($urandom_range(0, 4)), 1'($urandom), 1'($urandom), 1'($urandom));

        run_win(1'b0, 1'b0);
        run_win(1'b0, 1'b1);
        run_win(1'b1, 1'b0);
        for (int i = 0; i < 4; i++) run_win(1'($urandom), 1'($urandom));
        run_parked_win(1'b1);
        run_parked_win(1'b0);

        // R12: reset in the middle of a program
        cyc(); op_start = 1; op_is_erase = 0; prog_bit7 = 1; engine_busy = 1; target_prot = 0;
        cyc();
        #1 expect2("R3 before reset", 1, 0);
        cyc(); rst = 1;
        cyc(); rst = 0;
        #1 expect2("R12 reset ends program", 0, array_bit7);
        cyc();
        #1 expect2("R12 stays idle", 0, array_bit7);
        engine_busy = 0;

        // R12: reset in the middle of a protected erase window
        cyc(); op_start = 1; op_is_erase = 1; target_prot = 1;
        cyc(); target_prot = 0;
        cyc();
        #1 expect2("R9 window before reset", 1, 0);
        cyc(); rst = 1;
        cyc(); rst = 0;
        #1 expect2("R12 reset ends window", 0, array_bit7);
        for (int i = 0; i < EW; i++) begin
            cyc();
            #1 expect2("R12 no stale window", 0, array_bit7);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule